// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Access

This block collects up to 32 interrupt lines from peripherals and raises one request line towards a processor. A parameter bit for each input picks how that input is captured. An edge-type input latches its status bit on a rising edge. A level-type input sets its status bit again on every cycle while the line is high. Software reaches the block through a plain 32-bit register bus with word-aligned byte offsets.

Software can load the enable mask directly. It can also set or clear single enable bits through two write-one registers, which avoids a read-modify-write. Writing ones to the acknowledge register clears latched status bits. The vector register reports the lowest-numbered source that is both latched and enabled, and it reads as all ones when no such source exists. A two-bit master register gates the request line: both of its bits must be 1 before the request can rise.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the status, enable and master registers read zero, `irq_out` is 0, and `bus_rdata` is 0.
- R2: Writing to offset 0x10 sets each enable bit whose write-data bit is 1 and leaves the enable bits under 0s unchanged.
- R3: Writing to offset 0x14 clears each enable bit whose write-data bit is 1 and leaves the enable bits under 0s unchanged.
- R4: Writing to offset 0x08 loads the enable register with the write data, and reading 0x08 returns it.
- R5: An edge-type input (its `EDGE_MASK` bit is 1) sets its status bit at offset 0x00 on a rising edge only. After an acknowledge, an input that stays high does not set the bit again.
- R6: A level-type input (its `EDGE_MASK` bit is 0) keeps its status bit set while the line is high, even across acknowledges. Once the line is low, the bit holds until it is acknowledged.
- R7: Writing to offset 0x0C clears each status bit whose write-data bit is 1, and writing all ones clears every status bit.
- R8: Offset 0x04 reads the status register ANDed with the enable register.
- R9: Offset 0x18 reads the index of the lowest-numbered pending bit (input 0 has the highest priority), or 0xFFFFFFFF when no bit is pending.
- R10: `irq_out` is 1 exactly one cycle after a state in which any pending bit is set and both master bits are 1. It is 0 otherwise.
- R11: A read at a word offset of 0x20 or above, or at an address that is not word-aligned, returns zero.
- R12: Offset 0x1C holds the master register. Bit 0 is the master enable, bit 1 is the hardware request enable, and the register reads back what was written in those two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_SRC | Interrupt inputs, synchronous to `clk` |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the address of the previous cycle |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
A single one-cycle pulse on an edge-type line is compared with the same line held high across an acknowledge. This separates rising-edge capture from level capture. A level-type line is held high through an acknowledge and then dropped, which shows that its bit sets again while the line is high and is kept until acknowledged after the line falls. Two edge pulses in the same cycle, acknowledged one at a time, check the vector order. The master bits are tried one at a time and then together, which shows that the request needs both. Reads at unaligned and out-of-range addresses are made while state is non-zero, so that a decode fault would show up as non-zero data.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // Word index of each register within the 8-word window
  typedef enum logic [2:0] {
    SEL_STAT   = 3'd0,
    SEL_PEND   = 3'd1,
    SEL_ENA    = 3'd2,
    SEL_ACK    = 3'd3,
    SEL_SETEN  = 3'd4,
    SEL_CLREN  = 3'd5,
    SEL_VEC    = 3'd6,
    SEL_MASTER = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/vic_source.sv
module vic_source #(
  parameter bit EDGE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic irq_in,
  input  logic ack,
  output logic stat
);
  logic prev_q;
  logic stat_q;
  logic set_now;

  generate
    if (EDGE) begin : g_edge
      assign set_now = irq_in & ~prev_q;
    end else begin : g_level
      assign set_now = irq_in;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= irq_in;
      stat_q <= (stat_q & ~ack) | set_now;
    end
  end

  assign stat = stat_q;

  generate
    if (EDGE) begin : g_edge_chk
      // R5
      edge_no_relatch_chk: assert property (@(posedge clk) disable iff (rst)
        (!stat_q && !(irq_in && !prev_q)) |=> !stat_q);
    end else begin : g_level_chk
      // R6
      level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        irq_in |=> stat_q);
    end
  endgenerate
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  // R9
  prio_pick_chk: assert property (@(posedge clk) disable iff (rst)
    found |-> (req[idx] && ((req & ((N_SRC'(1) << idx) - N_SRC'(1))) == '0)));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int          N_SRC     = 8,
  parameter logic [31:0] EDGE_MASK = 32'h0000_000F,
  parameter int          ADDR_W    = 6,
  parameter int          DATA_W    = 32,
  localparam int         IDX_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  logic [N_SRC-1:0] stat_vec;
  logic [N_SRC-1:0] ena_q;
  logic [1:0]       mer_q;
  logic [N_SRC-1:0] ack_vec;
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] wbits;
  logic             hit;
  reg_sel_e         sel;
  logic             found;
  logic [IDX_W-1:0] idx;
  logic             unused_ok;

  assign unused_ok = ^bus_wdata;
  assign wbits     = bus_wdata[N_SRC-1:0];
  assign hit       = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 5) == '0);
  assign sel       = reg_sel_e'(bus_addr[4:2]);
  assign ack_vec   = (bus_wr && hit && sel == SEL_ACK) ? wbits : '0;
  assign pend      = stat_vec & ena_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    vic_source #(.EDGE(EDGE_MASK[i])) u_src (
      .clk   (clk),
      .rst   (rst),
      .irq_in(irq_in[i]),
      .ack   (ack_vec[i]),
      .stat  (stat_vec[i])
    );
  end

  vic_prio #(.N_SRC(N_SRC)) u_prio (
    .clk  (clk),
    .rst  (rst),
    .req  (pend),
    .found(found),
    .idx  (idx)
  );

  // Enable and master registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ena_q <= '0;
      mer_q <= 2'b00;
    end else if (bus_wr && hit) begin
      case (sel)
        SEL_ENA:    ena_q <= wbits;
        SEL_SETEN:  ena_q <= ena_q | wbits;
        SEL_CLREN:  ena_q <= ena_q & ~wbits;
        SEL_MASTER: mer_q <= bus_wdata[1:0];
        default:    ;
      endcase
    end
  end

  // Registered read data and request
  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (hit) begin
      case (sel)
        SEL_STAT:   rd_next = DATA_W'(stat_vec);
        SEL_PEND:   rd_next = DATA_W'(pend);
        SEL_ENA:    rd_next = DATA_W'(ena_q);
        SEL_VEC:    rd_next = found ? DATA_W'(idx) : '1;
        SEL_MASTER: rd_next = DATA_W'(mer_q);
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      bus_rdata <= rd_next;
      irq_out   <= (|pend) & mer_q[0] & mer_q[1];
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ena_q == '0 && mer_q == 2'b00 && !irq_out));

  // R2
  set_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit && sel == SEL_SETEN) |=>
      ((ena_q & $past(wbits)) == $past(wbits)) &&
      ((ena_q & ~$past(wbits)) == ($past(ena_q) & ~$past(wbits))));

  // R3
  clr_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit && sel == SEL_CLREN) |=>
      ((ena_q & $past(wbits)) == '0) &&
      ((ena_q & ~$past(wbits)) == ($past(ena_q) & ~$past(wbits))));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !(mer_q[0] && mer_q[1]) |=> !irq_out);
endmodule

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;
  localparam int N_SRC  = 8;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst;
  logic [N_SRC-1:0]  irq_in;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_wr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq_out;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  vec_irq_ctrl #(
    .N_SRC(N_SRC), .EDGE_MASK(32'h0000_000F), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [N_SRC-1:0] m);
    @(negedge clk);
    irq_in = irq_in | m;
    @(negedge clk);
    irq_in = irq_in & ~m;
  endtask

  task automatic t_reset;
    rd_chk("R1 status", 6'h00, 32'h0);
    rd_chk("R1 enable", 6'h08, 32'h0);
    rd_chk("R1 master", 6'h1C, 32'h0);
    check("R1 irq_out", {31'b0, irq_out}, 32'h0);
    rd_chk("R9 vector idle", 6'h18, 32'hFFFF_FFFF);
  endtask

  task automatic t_enables;
    wr(6'h10, 32'h05); rd_chk("R2 set first", 6'h08, 32'h05);
    wr(6'h10, 32'h02); rd_chk("R2 set keeps others", 6'h08, 32'h07);
    wr(6'h14, 32'h04); rd_chk("R3 clear one", 6'h08, 32'h03);
    wr(6'h14, 32'h00); rd_chk("R3 zeros no effect", 6'h08, 32'h03);
    wr(6'h08, 32'hA0); rd_chk("R4 direct load", 6'h08, 32'hA0);
    wr(6'h08, 32'h00);
  endtask

  task automatic t_edge;
    pulse(8'h04);
    rd_chk("R5 edge latched", 6'h00, 32'h04);
    rd_chk("R8 pending masked", 6'h04, 32'h0);
    rd_chk("R9 vector masked", 6'h18, 32'hFFFF_FFFF);
    wr(6'h10, 32'h04);
    rd_chk("R8 pending enabled", 6'h04, 32'h04);
    rd_chk("R9 vector two", 6'h18, 32'd2);
    wr(6'h0C, 32'h04);
    rd_chk("R7 ack clears", 6'h00, 32'h0);
    @(negedge clk); irq_in[1] = 1'b1;
    rd_chk("R5 held edge latched", 6'h00, 32'h02);
    wr(6'h0C, 32'h02);
    repeat (3) @(negedge clk);
    rd_chk("R5 held high no relatch", 6'h00, 32'h0);
    irq_in[1] = 1'b0;
    wr(6'h08, 32'h00);
  endtask

  task automatic t_level;
    @(negedge clk); irq_in[5] = 1'b1;
    rd_chk("R6 level set", 6'h00, 32'h20);
    wr(6'h0C, 32'h20);
    rd_chk("R6 ack while high", 6'h00, 32'h20);
    @(negedge clk); irq_in[5] = 1'b0;
    repeat (2) @(negedge clk);
    rd_chk("R6 held after drop", 6'h00, 32'h20);
    wr(6'h0C, 32'h20);
    rd_chk("R6 ack after drop", 6'h00, 32'h0);
  endtask

  task automatic t_prio;
    wr(6'h08, 32'hFF);
    pulse(8'h0A);
    rd_chk("R9 lowest first", 6'h18, 32'd1);
    wr(6'h0C, 32'h02);
    rd_chk("R9 next source", 6'h18, 32'd3);
    pulse(8'h01);
    wr(6'h0C, 32'hFFFF_FFFF);
    rd_chk("R7 ack all status", 6'h00, 32'h0);
    rd_chk("R7 ack all vector", 6'h18, 32'hFFFF_FFFF);
    wr(6'h08, 32'h00);
  endtask

  task automatic t_irq;
    wr(6'h08, 32'h01);
    pulse(8'h01);
    wr(6'h1C, 32'h1);
    repeat (2) @(negedge clk);
    check("R10 only master enable", {31'b0, irq_out}, 32'h0);
    wr(6'h1C, 32'h2);
    repeat (2) @(negedge clk);
    check("R10 only hw enable", {31'b0, irq_out}, 32'h0);
    wr(6'h1C, 32'h3);
    repeat (2) @(negedge clk);
    check("R10 both enables", {31'b0, irq_out}, 32'h1);
    rd_chk("R12 master readback", 6'h1C, 32'h3);
    wr(6'h14, 32'h01);
    repeat (2) @(negedge clk);
    check("R10 disabled source", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_unmapped;
    rd_chk("R11 status nonzero", 6'h00, 32'h01);
    rd_chk("R11 offset 0x20", 6'h20, 32'h0);
    rd_chk("R11 offset 0x3C", 6'h3C, 32'h0);
    rd_chk("R11 unaligned", 6'h1D, 32'h0);
    wr(6'h0C, 32'hFFFF_FFFF);
  endtask

  initial begin
    irq_in = '0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enables();
    t_edge();
    t_level();
    t_prio();
    t_irq();
    t_unmapped();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule